// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block turns a watchdog timeout into a reset pulse on an external pin. It holds one configuration register. The low bits give the pulse length in microseconds, stored as the length minus one. Two flags select the pin polarity (active-high or active-low) and the drive style (push-pull or open-drain). A flag can only be set or cleared by a write whose top byte carries the matching key. The pulse width field is updated by every write, whatever its top byte holds.

A timeout trigger starts a pulse. The pulse lasts for a counted number of 1 MHz tick strobes and then ends. A trigger that arrives while a pulse is running has no effect. The outputs are a pad data bit and a pad output-enable. In open-drain mode the pad is driven only while a pulse is active and the active level is low; at every other time the pad floats.

The sequencer has two named states. `S_IDLE` goes to `S_PULSE` when the trigger is seen, and loads the down-counter from the width field. `S_PULSE` counts down by one on each tick. It goes back to `S_IDLE` on the tick that finds the counter at zero.

Top module: `ext_reset_pulser`

## Requirements
- R1: After reset the register reads 0 (active-low, open-drain, width field 0). The pad is not driven (`pad_oe`=0, `pad_do`=0), and a trigger gives a pulse of exactly 1 tick.
- R2: Every write loads the width field, bits [PULSE_W-1:0], from the same bits of `wr_data`, whatever the top byte holds. Readback bits [29:PULSE_W] are always 0.
- R3: A write with `wr_data[31:24]` = 8'hA5 sets the active-high flag, read back at bit 31. A write with 8'h5A clears it.
- R4: A write with `wr_data[31:24]` = 8'hA8 sets the push-pull flag, read back at bit 30. A write with 8'h8A clears it.
- R5: A write whose top byte is none of the four keys leaves both flags unchanged.
- R6: After a trigger in `S_IDLE`, the pin stays asserted through exactly field+1 tick strobes and is released on the last of them.
- R7: A trigger that arrives during an active pulse neither lengthens the pulse nor starts a new one after it ends.
- R8: In push-pull mode `pad_oe` is 1 at all times. `pad_do` equals the active level during a pulse and the inactive level otherwise.
- R9: In open-drain mode `pad_do` is 0. `pad_oe` is 1 only while a pulse is active and the flag selects active-low. In active-high open-drain mode `pad_oe` stays 0.
- R10: A write during an active pulse does not change the length of that pulse. The new width applies from the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: key in [31:24], width in [PULSE_W-1:0] |
| rd_data | output | 32 | Readback: active-high flag [31], push-pull flag [30], width field [PULSE_W-1:0] |
| tick_1us | input | 1 | One-cycle strobe at 1 MHz |
| timeout | input | 1 | Watchdog timeout trigger |
| pad_do | output | 1 | Pad output data |
| pad_oe | output | 1 | Pad output enable |

## Verification
The bench builds the block with PULSE_W=8, not the default of 20. With that setting the largest field value, 255, gives a 256-tick pulse, so the longest pulse can be measured end to end in a few hundred cycles. The narrower field also makes the width field and the zero-filled readback gap [29:8] both visible within one readback word. The tick strobe arrives every third cycle, so the pulse length is checked in ticks and not in clock cycles.

// File: rtl/erp_pkg.sv
package erp_pkg;
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_PULSE = 1'b1
    } erp_state_e;

    localparam logic [7:0] KEY_HI_SET = 8'hA5;
    localparam logic [7:0] KEY_HI_CLR = 8'h5A;
    localparam logic [7:0] KEY_PP_SET = 8'hA8;
    localparam logic [7:0] KEY_PP_CLR = 8'h8A;
endpackage

// File: rtl/erp_cfg_reg.sv
module erp_cfg_reg
    import erp_pkg::*;
#(
    parameter int PULSE_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic               act_hi,
    output logic               push_pull,
    output logic [PULSE_W-1:0] width
);
    localparam int GAP_W = 30 - PULSE_W;

    logic [7:0] key;
    assign key = wr_data[31:24];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi    <= 1'b0;
            push_pull <= 1'b0;
            width     <= '0;
        end else if (wr_en) begin
            width <= wr_data[PULSE_W-1:0];
            unique case (key)
                KEY_HI_SET: act_hi    <= 1'b1;
                KEY_HI_CLR: act_hi    <= 1'b0;
                KEY_PP_SET: push_pull <= 1'b1;
                KEY_PP_CLR: push_pull <= 1'b0;
                default: ;
            endcase
        end
    end

    a_r2_width_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> width == $past(wr_data[PULSE_W-1:0]));
    a_r3_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'hA5) |=> act_hi);
    a_r4_pp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'h8A) |=> !push_pull);
    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !(wr_data[31:24] inside {8'hA5, 8'h5A, 8'hA8, 8'h8A}))
        |=> ($stable(act_hi) && $stable(push_pull)));
    initial begin
        a_r2_gap_size: assert (GAP_W >= 1);
    end
endmodule

// File: rtl/erp_pulse_fsm.sv
module erp_pulse_fsm
    import erp_pkg::*;
#(
    parameter int PULSE_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               timeout,
    input  logic               tick_1us,
    input  logic [PULSE_W-1:0] width,
    output logic               active
);
    erp_state_e         st, st_nx;
    logic [PULSE_W-1:0] cnt, cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            S_IDLE: begin
                if (timeout) begin
                    st_nx  = S_PULSE;
                    cnt_nx = width;
                end
            end
            S_PULSE: begin
                if (tick_1us) begin
                    if (cnt == '0) st_nx = S_IDLE;
                    else           cnt_nx = cnt - 1'b1;
                end
            end
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        active = (st == S_PULSE);
    end

    a_r6_end_on_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && $past(st) == S_PULSE) |-> ($past(tick_1us) && $past(cnt) == '0));
    a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PULSE && $past(st) == S_PULSE)
        |-> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
    a_r6_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && timeout) |=> (st == S_PULSE && cnt == $past(width)));
endmodule

// File: rtl/erp_pad_drive.sv
module erp_pad_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic act_hi,
    input  logic push_pull,
    output logic pad_do,
    output logic pad_oe
);
    logic level;

    always_comb begin
        level = active ? act_hi : ~act_hi;
        if (push_pull) begin
            pad_do = level;
            pad_oe = 1'b1;
        end else begin
            pad_do = 1'b0;
            pad_oe = active & ~act_hi;
        end
    end

    a_r9_od_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && pad_oe) |-> (active && !act_hi && !pad_do));
    a_r8_pp_driven: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> (pad_oe && (pad_do == (active == act_hi))));
endmodule

// File: rtl/ext_reset_pulser.sv
module ext_reset_pulser #(
    parameter int PULSE_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        tick_1us,
    input  logic        timeout,
    output logic        pad_do,
    output logic        pad_oe
);
    localparam int GAP_W = 30 - PULSE_W;

    logic               act_hi, push_pull, active;
    logic [PULSE_W-1:0] width;

    erp_cfg_reg #(.PULSE_W(PULSE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .act_hi(act_hi), .push_pull(push_pull), .width(width)
    );

    erp_pulse_fsm #(.PULSE_W(PULSE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .timeout(timeout), .tick_1us(tick_1us),
        .width(width), .active(active)
    );

    erp_pad_drive u_pad (
        .clk(clk), .rst_n(rst_n), .active(active), .act_hi(act_hi),
        .push_pull(push_pull), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    assign rd_data = {act_hi, push_pull, {GAP_W{1'b0}}, width};
endmodule

// File: tb/ext_reset_pulser_bench.sv
module ext_reset_pulser_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_1us = 1'b0;
    logic        timeout = 1'b0;
    logic        pad_do, pad_oe;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_reset_pulser #(.PULSE_W(PW)) u_ext_reset_pulser (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_1us(tick_1us), .timeout(timeout),
        .pad_do(pad_do), .pad_oe(pad_oe)
    );

    // {write data, expected readback}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'hA500_0012, 32'h8000_0012},  // R3 set hi, R2 width
        {32'hA800_00FF, 32'hC000_00FF},  // R4 set pp
        {32'h1234_5633, 32'hC000_0033},  // R5 no key, R2 upper bits dropped
        {32'h5A00_0001, 32'h4000_0001},  // R3 clear hi
        {32'h8A00_0007, 32'h0000_0007},  // R4 clear pp
        {32'hA4FF_FF05, 32'h0000_0005},  // R5 near-key
        {32'hA5FF_FF00, 32'h8000_0000},  // R3 R2
        {32'h5B00_0000, 32'h8000_0000}   // R5 near-key
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Trigger a pulse and count tick strobes while asserted.
    // use_oe selects pad_oe (open-drain low) or pad_do (push-pull high) as "asserted".
    task automatic measure(input bit use_oe, input bit mid_trig, input bit mid_wr,
                           output int n);
        n = 0;
        @(negedge clk);
        timeout = 1'b1;
        @(negedge clk);
        timeout = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            bit asrt;
            asrt = use_oe ? pad_oe : pad_do;
            if (!asrt) begin
                tick_1us = 1'b0;
                wr_en = 1'b0;
                timeout = 1'b0;
                break;
            end
            tick_1us = (i % 3 == 2);
            timeout  = mid_trig && (i == 6);
            wr_en    = mid_wr && (i == 6);
            wr_data  = (mid_wr && i == 6) ? 32'h0000_0002 : 32'h0;
            if (tick_1us) n++;
            @(negedge clk);
        end
        tick_1us = 1'b0;
        timeout = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic mode_check(input logic [31:0] k1, input logic [31:0] k2,
                              input bit idle_do, input bit idle_oe,
                              input bit act_do, input bit act_oe, input string req);
        reg_write(k1);
        reg_write(k2);
        @(negedge clk);
        check(pad_do == idle_do && pad_oe == idle_oe, {req, " idle"},
              {30'd0, pad_do, pad_oe}, {30'd0, idle_do, idle_oe});
        timeout = 1'b1;
        @(negedge clk);
        timeout = 1'b0;
        check(pad_do == act_do && pad_oe == act_oe, {req, " active"},
              {30'd0, pad_do, pad_oe}, {30'd0, act_do, act_oe});
        tick_1us = 1'b1;
        repeat (6) @(negedge clk);
        tick_1us = 1'b0;
        check(pad_do == idle_do && pad_oe == idle_oe, {req, " released"},
              {30'd0, pad_do, pad_oe}, {30'd0, idle_do, idle_oe});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0, "R1 readback", rd_data, 32'h0);
        check(!pad_do && !pad_oe, "R1 pad idle", {30'd0, pad_do, pad_oe}, 32'h0);
        measure(1'b1, 1'b0, 1'b0, n);
        check(n == 1, "R1 R6 reset pulse ticks", n, 1);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            reg_write(VEC[v][63:32]);
            check(rd_data == VEC[v][31:0], "R2 R3 R4 R5 readback", rd_data, VEC[v][31:0]);
        end

        // R6 pulse lengths in push-pull active-high
        reg_write(32'hA800_0000);
        reg_write(32'hA500_0004);
        measure(1'b0, 1'b0, 1'b0, n);
        check(n == 5, "R6 width 4", n, 5);
        reg_write(32'h0000_00FF);
        measure(1'b0, 1'b0, 1'b0, n);
        check(n == 256, "R6 max width", n, 256);

        // R7 trigger mid-pulse
        reg_write(32'h0000_0009);
        measure(1'b0, 1'b1, 1'b0, n);
        check(n == 10, "R7 mid trigger length", n, 10);
        repeat (10) @(negedge clk);
        check(!pad_do, "R7 no re-pulse", {31'd0, pad_do}, 32'h0);

        // R10 write during pulse
        measure(1'b0, 1'b0, 1'b1, n);
        check(n == 10, "R10 length kept", n, 10);
        check(rd_data == 32'hC000_0002, "R10 R5 new width stored", rd_data, 32'hC000_0002);
        measure(1'b0, 1'b0, 1'b0, n);
        check(n == 3, "R10 new width next pulse", n, 3);

        // R8 R9 pad modes
        mode_check(32'hA500_0003, 32'hA800_0003, 1'b0, 1'b1, 1'b1, 1'b1, "R8 pp high");
        mode_check(32'h5A00_0003, 32'hA800_0003, 1'b1, 1'b1, 1'b0, 1'b1, "R8 pp low");
        mode_check(32'h5A00_0003, 32'h8A00_0003, 1'b0, 1'b0, 1'b0, 1'b1, "R9 od low");
        mode_check(32'hA500_0003, 32'h8A00_0003, 1'b0, 1'b0, 1'b0, 1'b0, "R9 od high");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule